// File: doc/BRIEF.md
# Selectable-Mode Accumulator Rounding Unit

This block reduces a 36-bit extended accumulator word to single precision. The word has three parts: 4 guard (extension) bits at the top, a 16-bit high half in the middle and a 16-bit low half at the bottom. Rounding happens at the boundary between bit 16 and bit 15. The low half decides whether one is added at bit 16. A mode input chooses how an exact half is settled: either round-to-nearest-even or always round upward. The unit returns the rounded accumulator with its low half cleared. It also returns the 16-bit word formed from bits 31:16 of that result, which is ready to be stored.

One register stage sits between the input and the output. The unit samples a value and its mode in every cycle where `valid_i` is high. The result and `valid_o` appear one clock later. A two-state controller tracks whether the output register holds a fresh result. State `ST_EMPTY` moves to `ST_FULL` on an accepted input (transition *accept*) and stays in `ST_FULL` while inputs keep arriving (*stream*). It returns to `ST_EMPTY` on a cycle with no input (*drain*) and stays there while idle (*idle*). A synchronous reset forces `ST_EMPTY`.

Top module: `acc_round_unit`

## Requirements
- R1: The input `acc_i` is taken as {guard[35:32], high[31:16], low[15:0]}. Bits 15:0 of `acc_o` are always 0 in a produced result.
- R2: If low is greater than 0x8000, `acc_o[35:16]` equals the input bits 35:16 plus one.
- R3: If low is less than 0x8000, `acc_o[35:16]` equals the input bits 35:16 unchanged.
- R4: With `mode_i` = 0 (convergent, the encoding cleared by reset), a low half of exactly 0x8000 rounds up when input bit 16 is 1. It leaves bits 35:16 unchanged when bit 16 is 0.
- R5: With `mode_i` = 1 (two's-complement), a low half of exactly 0x8000 always adds one at bit 16.
- R6: The carry from rounding ripples through bits 35:16, guard bits included, and wraps modulo 2^36 with no saturation. For example, 0xF_FFFF_8001 gives 0x0_0000_0000.
- R7: `word_o` equals bits 31:16 of the rounded result.
- R8: An input accepted with `valid_i` high at a rising edge gives `valid_o` = 1 and its result on `acc_o`/`word_o` after that edge. This holds for one cycle, or longer while inputs stream.
- R9: In a cycle with `valid_i` low, the next edge clears `valid_o` and leaves `acc_o` and `word_o` unchanged. A synchronous active-high `rst` clears `valid_o`, `acc_o` and `word_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Input value and mode are valid this cycle |
| mode_i | input | 1 | 0 = convergent tie-break, 1 = two's-complement tie-break |
| acc_i | input | 36 | Extended accumulator value to round |
| valid_o | output | 1 | Result registers hold the result of the previous cycle's input |
| acc_o | output | 36 | Rounded accumulator, low half cleared |
| word_o | output | 16 | Single-precision rounded word (bits 31:16) |

## Verification
Every result is due exactly one rising edge after the cycle in which `valid_i` was high. The bench drives each input on a falling edge and lets one rising edge pass. It then reads `valid_o`, `acc_o` and `word_o` on the next falling edge, so each check lines up with that single register stage. The bench sweeps guard, high and low values around the half point in both modes, including both signs and the wrap case. For the hold and drain checks, the bench removes `valid_i`, changes `acc_i`, and checks one edge later that the outputs kept their previous values and `valid_o` fell.

// File: rtl/acc_rnd_pkg.sv
package acc_rnd_pkg;

    // Tie-break selection; encoding 0 is the reset default (convergent).
    typedef enum logic {
        RM_CONVERGENT = 1'b0,
        RM_TWOS       = 1'b1
    } rmode_e;

    // Output register occupancy.
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } pstate_e;

    // Where the discarded low half sits relative to one-half.
    typedef enum logic [1:0] {
        LC_BELOW = 2'd0,
        LC_TIE   = 2'd1,
        LC_ABOVE = 2'd2
    } lclass_e;

endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
    import acc_rnd_pkg::*;
#(
    parameter int LO_W = 16
) (
    input  logic [LO_W-1:0] lo,
    input  logic            keep_lsb,
    input  rmode_e          mode,
    output logic            bump
);
    localparam logic [LO_W-1:0] HALF = {1'b1, {(LO_W-1){1'b0}}};

    lclass_e cls;

    always_comb begin
        if (lo > HALF)       cls = LC_ABOVE;
        else if (lo == HALF) cls = LC_TIE;
        else                 cls = LC_BELOW;
    end

    always_comb begin
        unique case (cls)
            LC_ABOVE: bump = 1'b1;
            LC_TIE:   bump = (mode == RM_TWOS) ? 1'b1 : keep_lsb;
            default:  bump = 1'b0;
        endcase
    end

endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
    parameter int UP_W = 20,
    parameter int LO_W = 16
) (
    input  logic [UP_W-1:0]      upper,
    input  logic                 bump,
    output logic [UP_W+LO_W-1:0] rounded
);
    logic [UP_W-1:0] sum;

    always_comb begin
        sum     = upper + {{(UP_W-1){1'b0}}, bump};
        rounded = {sum, {LO_W{1'b0}}};
    end

endmodule

// File: rtl/acc_round_unit.sv
module acc_round_unit
    import acc_rnd_pkg::*;
#(
    parameter int EXT_W = 4,
    parameter int HI_W  = 16,
    parameter int LO_W  = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           valid_i,
    input  logic                           mode_i,
    input  logic [EXT_W+HI_W+LO_W-1:0]     acc_i,
    output logic                           valid_o,
    output logic [EXT_W+HI_W+LO_W-1:0]     acc_o,
    output logic [HI_W-1:0]                word_o
);
    localparam int UP_W  = EXT_W + HI_W;
    localparam int ACC_W = UP_W + LO_W;
    localparam logic [LO_W-1:0] HALF = {1'b1, {(LO_W-1){1'b0}}};

    pstate_e          state_q, state_d;
    logic             bump;
    logic [ACC_W-1:0] rounded;
    logic [ACC_W-1:0] acc_q;

    rnd_decide #(.LO_W(LO_W)) u_decide (
        .lo       (acc_i[LO_W-1:0]),
        .keep_lsb (acc_i[LO_W]),
        .mode     (rmode_e'(mode_i)),
        .bump     (bump)
    );

    rnd_incr #(.UP_W(UP_W), .LO_W(LO_W)) u_incr (
        .upper   (acc_i[ACC_W-1:LO_W]),
        .bump    (bump),
        .rounded (rounded)
    );

    // Next-state logic: accept / stream / drain / idle.
    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = valid_i ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = valid_i ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    // Result register: loads only on accepted input.
    always_ff @(posedge clk) begin
        if (rst)          acc_q <= '0;
        else if (valid_i) acc_q <= rounded;
    end

    assign valid_o = (state_q == ST_FULL);
    assign acc_o   = acc_q;
    assign word_o  = acc_q[LO_W+HI_W-1:LO_W];

    p_low_clear_r1: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> (acc_o[LO_W-1:0] == '0));

    p_round_up_r2: assert property (@(posedge clk) disable iff (rst)
        (valid_i && acc_i[LO_W-1:0] > HALF) |=>
        (acc_o[ACC_W-1:LO_W] == UP_W'($past(acc_i[ACC_W-1:LO_W]) + 1'b1)));

    p_round_down_r3: assert property (@(posedge clk) disable iff (rst)
        (valid_i && acc_i[LO_W-1:0] < HALF) |=>
        (acc_o[ACC_W-1:LO_W] == $past(acc_i[ACC_W-1:LO_W])));

    p_tie_even_r4: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !mode_i && acc_i[LO_W-1:0] == HALF && !acc_i[LO_W]) |=>
        (acc_o[ACC_W-1:LO_W] == $past(acc_i[ACC_W-1:LO_W])));

    p_tie_twos_r5: assert property (@(posedge clk) disable iff (rst)
        (valid_i && mode_i && acc_i[LO_W-1:0] == HALF) |=>
        (acc_o[ACC_W-1:LO_W] == UP_W'($past(acc_i[ACC_W-1:LO_W]) + 1'b1)));

    p_valid_next_r8: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> valid_o);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> (!valid_o && $stable(acc_o)));

endmodule

// File: tb/acc_round_unit_tb.sv
module acc_round_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic        mode_i;
    logic [35:0] acc_i;
    logic        valid_o;
    logic [35:0] acc_o;
    logic [15:0] word_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_round_unit u_dut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .mode_i(mode_i),
        .acc_i(acc_i), .valid_o(valid_o), .acc_o(acc_o), .word_o(word_o)
    );

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] model(input logic [35:0] v, input logic m);
        logic [19:0] up;
        logic        inc;
        inc = (v[15:0] > 16'h8000) ||
              (v[15:0] == 16'h8000 && (m || v[16]));
        up  = v[35:16] + {19'd0, inc};
        return {up, 16'h0000};
    endfunction

    function automatic string tag(input logic [35:0] v, input logic m);
        logic [19:0] up;
        if (v[15:0] < 16'h8000) return "R3";
        up = v[35:16];
        if (up == 20'hFFFFF) return "R6";
        if (v[15:0] > 16'h8000) return "R2";
        return m ? "R5" : "R4";
    endfunction

    task automatic apply(input logic [35:0] v, input logic m);
        logic [35:0] e;
        e = model(v, m);
        @(negedge clk);
        valid_i = 1'b1; mode_i = m; acc_i = v;
        @(posedge clk);
        @(negedge clk);
        valid_i = 1'b0;
        chk("R8 valid_o", {35'd0, valid_o}, 36'd1);
        chk(tag(v, m), acc_o, e);
        chk("R1 low half", {20'd0, acc_o[15:0]}, 36'd0);
        chk("R7 word_o", {20'd0, word_o}, {20'd0, e[31:16]});
    endtask

    initial begin
        logic [15:0] his[6];
        logic [3:0]  exts[4];
        logic [15:0] los[6];
        logic [35:0] last;
        his  = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFE, 16'hFFFF};
        exts = '{4'h0, 4'h7, 4'h8, 4'hF};
        los  = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'h8001, 16'hFFFF};
        rst = 1'b1; valid_i = 1'b0; mode_i = 1'b0; acc_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset valid_o", {35'd0, valid_o}, 36'd0);
        chk("R9 reset acc_o", acc_o, 36'd0);
        chk("R9 reset word_o", {20'd0, word_o}, 36'd0);
        rst = 1'b0;

        // Named tie cases, both signs
        apply(36'h0_0002_8000, 1'b0);   // R4 even rounds down
        apply(36'h0_0003_8000, 1'b0);   // R4 odd rounds up
        apply(36'hF_FFF2_8000, 1'b1);   // R5 even rounds up
        apply(36'hF_FFF3_8000, 1'b1);   // R5 odd rounds up
        apply(36'hF_FFFF_8001, 1'b0);   // R6 wrap to zero

        // Sweep
        for (int m = 0; m < 2; m++)
            for (int e = 0; e < 4; e++)
                for (int h = 0; h < 6; h++)
                    for (int l = 0; l < 6; l++)
                        apply({exts[e], his[h], los[l]}, m[0]);

        // R9 hold: drop valid, change input, outputs keep last result
        last = model(36'h8_1234_9000, 1'b0);
        apply(36'h8_1234_9000, 1'b0);
        @(negedge clk);
        acc_i = 36'h0_5555_FFFF; mode_i = 1'b1; valid_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R9 hold valid_o", {35'd0, valid_o}, 36'd0);
        chk("R9 hold acc_o", acc_o, last);
        chk("R9 hold word_o", {20'd0, word_o}, {20'd0, last[31:16]});

        // R8 stream back-to-back
        @(negedge clk);
        valid_i = 1'b1; mode_i = 1'b0; acc_i = 36'h0_0001_8000;
        @(negedge clk);
        chk("R8 stream first", acc_o, model(36'h0_0001_8000, 1'b0));
        acc_i = 36'h7_0000_7FFF;
        @(negedge clk);
        valid_i = 1'b0;
        chk("R8 stream second", acc_o, model(36'h7_0000_7FFF, 1'b0));
        chk("R8 stream valid", {35'd0, valid_o}, 36'd1);

        // R9 synchronous reset clears outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 reset again", acc_o, 36'd0);
        chk("R9 reset valid", {35'd0, valid_o}, 36'd0);
        rst = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule